// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block turns the oscillator clock into 12-clock machine cycles and, within each one, drives the strobes and the address and data timing of an external memory bus. The bus uses multiplexed addressing. An 8-bit port carries the low address byte during an address-latch pulse. Later in the same slot it carries write data, or it is released so that read data or an instruction byte can be sampled. A second 8-bit port carries the high address byte.

Each machine cycle has two 6-clock code fetch slots, unless a data access was accepted for it. In that case the cycle becomes a single read or write with one long strobe. During such a cycle the second address pulse and both code strobes are left out.

The data pointer is either 16 bits wide or 8 bits wide. With an 8-bit pointer the high port shows a latch value supplied by the requester. An optional protection input clears the top four bits of code and 16-bit data addresses. This limits those accesses to the lowest 4K.

Top module: `xbus_seq`

## Requirements
- R1: A machine cycle lasts 12 clocks, numbered 0 to 11. Cycle 0 starts on the first clock edge after reset is released. `ale` is high during clocks 0-1 and 6-7 of every machine cycle, unless R2 applies.
- R2: In a data-access machine cycle, `ale` stays low during clocks 6-7, and `psen_n` stays high for the whole cycle.
- R3: Fetch slots are handled as follows.
  - When a fetch slot (clocks 0-5 or 6-11) is active, `psen_n` is low for the last three clocks of that slot, and `p0_oe` is low during those clocks.
  - `p0_in` is captured at the edge where `psen_n` rises. It appears on `code_byte`, with a one-clock `code_valid` pulse in the next clock.
  - The first slot samples `fetch_en` and `fetch_pc` at the edge that starts clock 0. The second slot samples them at the edge that starts clock 6.
- R4: During the first three clocks of every slot, `p0_oe` is high and `p0_out` holds the low address byte of that slot. The byte is therefore stable while `ale` is high and for one clock after `ale` falls.
- R5: In a data-access cycle, `rd_n` (read) or `wr_n` (write) is low for exactly 6 clocks, 5 through 10. That is 3 clocks after `ale` falls. The other strobe stays high.
- R6: In a write cycle, `p0_out` carries the write byte with `p0_oe` high from clock 3 through clock 11. This gives at least one clock of setup before `wr_n` falls and one clock of hold after it rises.
- R7: `p2_out` shows the high address byte, chosen as follows:
  - for a fetch slot, the high byte of that slot's PC;
  - for an access with `dat_wide`=1, the high byte of the 16-bit pointer;
  - for an access with `dat_wide`=0, `p2_latch`.
- R8: When `protect` is 1, bits 7:4 of `p2_out` are 0 for fetch slots and for accesses with `dat_wide`=1. An access with `dat_wide`=0 still shows `p2_latch` unchanged.
- R9: In a read cycle, `p0_oe` is low from clock 3 through clock 11. `p0_in` is captured at the edge where `rd_n` rises. It appears on `rdata`, with a one-clock `rdata_valid` pulse during clock 11.
- R10: `dat_req` is sampled in clock 11. `dat_ack` is high in exactly that clock when `dat_req` is high. An accepted request makes the next cycle a data access, even when `fetch_en` is high.
- R11: While reset is held, the outputs are as follows: `ale`=0, `psen_n`=1, `rd_n`=1, `wr_n`=1, `code_valid`=0 and `rdata_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_en | input | 1 | Request code fetches in the coming slot |
| fetch_pc | input | 16 | Code address for the coming slot |
| dat_req | input | 1 | Request an external data access |
| dat_wr | input | 1 | 1 = write, 0 = read |
| dat_wide | input | 1 | 1 = 16-bit pointer, 0 = 8-bit pointer plus latch |
| dat_addr | input | 16 | Data pointer (only the low byte is used when narrow) |
| dat_wdata | input | 8 | Write byte |
| p2_latch | input | 8 | High-port value for 8-bit pointer accesses |
| protect | input | 1 | Clear address bits 15:12 |
| dat_ack | output | 1 | Data request accepted this clock |
| ale | output | 1 | Address latch pulse |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Shared port drive value |
| p0_oe | output | 1 | Shared port drive enable |
| p0_in | input | 8 | Shared port pin value |
| p2_out | output | 8 | High address port drive value |
| code_byte | output | 8 | Last captured instruction byte |
| code_valid | output | 1 | `code_byte` updated |
| rdata | output | 8 | Last captured read byte |
| rdata_valid | output | 1 | `rdata` updated |

## Verification
The bench runs the sequencer through a random mix of machine cycles: two-slot fetches with unrelated PCs, idle cycles, reads, writes, wide and narrow pointers, and protection on or off. Each clock of every cycle is compared with a phase-by-phase model.

Fetch cycles with different PCs in the two slots show that each slot samples its own address and captures its own byte. Idle cycles show that `ale` keeps running while `psen_n` stays quiet. Read and write cycles with `fetch_en` held high show that data takes priority, and that the second `ale` and both code strobes are suppressed.

A directed sequence covers these cases:
- a protected wide access to a high address, which shows that the masking applies;
- a protected narrow access with a high latch value, which shows that the masking does not apply;
- back-to-back data cycles.

// File: rtl/xbus_seq.sv
`timescale 1ns/1ps
module xbus_seq (
  input  logic        clk,
  input  logic        rst,
  input  logic        fetch_en,
  input  logic [15:0] fetch_pc,
  input  logic        dat_req,
  input  logic        dat_wr,
  input  logic        dat_wide,
  input  logic [15:0] dat_addr,
  input  logic [7:0]  dat_wdata,
  input  logic [7:0]  p2_latch,
  input  logic        protect,
  output logic        dat_ack,
  output logic        ale,
  output logic        psen_n,
  output logic        rd_n,
  output logic        wr_n,
  output logic [7:0]  p0_out,
  output logic        p0_oe,
  input  logic [7:0]  p0_in,
  output logic [7:0]  p2_out,
  output logic [7:0]  code_byte,
  output logic        code_valid,
  output logic [7:0]  rdata,
  output logic        rdata_valid
);
  localparam logic [3:0] LAST = 4'd11;
  localparam logic [3:0] HALF = 4'd6;

  logic [3:0] ph;
  logic       is_data, is_wr, fetch_act;
  logic [7:0] lo_q, hi_q, wd_q;

  wire [3:0] slot   = (ph >= HALF) ? ph - HALF : ph;
  wire       strobe = is_data && ph >= 4'd5 && ph <= 4'd10;

  function automatic logic [7:0] hi_mask(input logic [7:0] h, input logic p);
    return p ? {4'b0000, h[3:0]} : h;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= LAST;
      is_data <= 1'b0;
      is_wr <= 1'b0;
      fetch_act <= 1'b0;
      lo_q <= '0;
      hi_q <= '0;
      wd_q <= '0;
      code_byte <= '0;
      code_valid <= 1'b0;
      rdata <= '0;
      rdata_valid <= 1'b0;
    end else begin
      code_valid  <= 1'b0;
      rdata_valid <= 1'b0;
      ph <= (ph == LAST) ? 4'd0 : ph + 4'd1;
      if (ph == LAST) begin
        is_data   <= dat_req;
        is_wr     <= dat_wr;
        wd_q      <= dat_wdata;
        fetch_act <= fetch_en && !dat_req;
        lo_q      <= dat_req ? dat_addr[7:0] : fetch_pc[7:0];
        hi_q      <= dat_req ? (dat_wide ? hi_mask(dat_addr[15:8], protect) : p2_latch)
                             : hi_mask(fetch_pc[15:8], protect);
      end else if (ph == 4'd5 && !is_data) begin
        fetch_act <= fetch_en;
        lo_q      <= fetch_pc[7:0];
        hi_q      <= hi_mask(fetch_pc[15:8], protect);
      end
      if (slot == 4'd5 && fetch_act && !is_data) begin
        code_byte  <= p0_in;
        code_valid <= 1'b1;
      end
      if (ph == 4'd10 && is_data && !is_wr) begin
        rdata       <= p0_in;
        rdata_valid <= 1'b1;
      end
    end
  end

  assign dat_ack = (ph == LAST) && dat_req && !rst;
  assign ale     = !rst && slot < 4'd2 && !(is_data && ph >= HALF);
  assign psen_n  = !(fetch_act && !is_data && slot >= 4'd3);
  assign rd_n    = !(strobe && !is_wr);
  assign wr_n    = !(strobe && is_wr);
  assign p0_oe   = is_data ? (ph < 4'd3 || is_wr) : (slot < 4'd3);
  assign p0_out  = (is_data && ph >= 4'd3) ? wd_q : lo_q;
  assign p2_out  = hi_q;

  a_r1_ale_width: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |=> ale ##1 !ale);
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({!psen_n, !rd_n, !wr_n}));
  a_r3_port_released: assert property (@(posedge clk) disable iff (rst)
    (!psen_n || !rd_n) |-> !p0_oe);
  a_r4_addr_hold: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |-> p0_oe && $stable(p0_out));
  a_r5_wr_width: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_n) |-> $past(!wr_n, 6) && $past(wr_n, 7));
  a_r5_rd_width: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_n) |-> $past(!rd_n, 6) && $past(rd_n, 7));
  a_r6_wdata_setup: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_n) |-> p0_oe && $past(p0_oe) && $stable(p0_out));
endmodule

// File: tb/xbus_seq_tb_top.sv
`timescale 1ns/1ps
module xbus_seq_tb_top;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst, fetch_en, dat_req, dat_wr, dat_wide, protect;
  logic [15:0] fetch_pc, dat_addr;
  logic [7:0] dat_wdata, p2_latch, p0_in;
  logic dat_ack, ale, psen_n, rd_n, wr_n, p0_oe, code_valid, rdata_valid;
  logic [7:0] p0_out, p2_out, code_byte, rdata;

  xbus_seq dut_i (.*);

  int nrun = 0, nfail = 0;
  bit done = 0;
  bit pend_v = 0;
  logic [7:0] pend_b = 0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nrun++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  function automatic logic [7:0] msk(input logic [7:0] h, input bit p);
    return p ? {4'h0, h[3:0]} : h;
  endfunction

  task automatic do_cycle(input bit d, input bit w, input bit wide, input bit fe,
                          input logic [15:0] pc1, input logic [15:0] pc2,
                          input logic [15:0] a, input logic [7:0] wd,
                          input logic [7:0] lat, input logic [7:0] rb, input bit prot);
    bit fa;
    dat_req = d; dat_wr = w; dat_wide = wide; dat_addr = a; dat_wdata = wd;
    p2_latch = lat; protect = prot; fetch_en = fe; fetch_pc = pc1;
    fa = fe && !d;
    #1;
    chk("R10 dat_ack", dat_ack, d);
    for (int k = 0; k < 12; k++) begin
      bit s, e_ale, e_ps, e_rd, e_wr, e_oe, e_cv, e_rv;
      logic [7:0] e_p0, e_p2;
      @(posedge clk); #1;
      if (k == 0) begin
        dat_req = 0;
        p0_in = d ? rb : mem(pc1);
        chk("R3 code_valid slot2", code_valid, pend_v);
        if (pend_v) chk("R3 code_byte slot2", code_byte, pend_b);
      end
      if (k == 3) fetch_pc = pc2;
      if (k == 6 && !d) p0_in = mem(pc2);
      s = (k >= 6);
      e_ale = (k % 6 < 2) && !(d && s);
      e_ps  = !(fa && (k % 6 >= 3));
      e_rd  = !(d && !w && k >= 5 && k <= 10);
      e_wr  = !(d && w && k >= 5 && k <= 10);
      e_oe  = d ? (k < 3 || w) : (k % 6 < 3);
      e_p0  = d ? ((k < 3) ? a[7:0] : wd) : (s ? pc2[7:0] : pc1[7:0]);
      e_p2  = d ? (wide ? msk(a[15:8], prot) : lat) : msk(s ? pc2[15:8] : pc1[15:8], prot);
      e_cv  = (k == 6) && fa;
      e_rv  = (k == 11) && d && !w;
      chk(d ? "R1 R2 ale" : "R1 ale", ale, e_ale);
      chk(d ? "R2 psen_n" : "R3 psen_n", psen_n, e_ps);
      chk("R5 rd_n", rd_n, e_rd);
      chk("R5 wr_n", wr_n, e_wr);
      chk(d ? (w ? "R6 p0_oe" : "R9 p0_oe") : "R3 R4 p0_oe", p0_oe, e_oe);
      if (e_oe) chk(d && k >= 3 ? "R6 p0_out" : "R4 p0_out", p0_out, e_p0);
      chk(prot ? "R8 p2_out" : "R7 p2_out", p2_out, e_p2);
      if (k != 0) chk("R3 code_valid", code_valid, e_cv);
      if (e_cv) chk("R3 code_byte slot1", code_byte, mem(pc1));
      chk("R9 rdata_valid", rdata_valid, e_rv);
      if (e_rv) chk("R9 rdata", rdata, rb);
    end
    pend_v = fa;
    pend_b = mem(pc2);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; fetch_en = 0; dat_req = 0; dat_wr = 0; dat_wide = 0; protect = 0;
    fetch_pc = 0; dat_addr = 0; dat_wdata = 0; p2_latch = 0; p0_in = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R11 ale", ale, 0);
    chk("R11 psen_n", psen_n, 1);
    chk("R11 rd_n", rd_n, 1);
    chk("R11 wr_n", wr_n, 1);
    chk("R11 code_valid", code_valid, 0);
    chk("R11 rdata_valid", rdata_valid, 0);
    rst = 0;
    do_cycle(0, 0, 0, 1, 16'h1234, 16'hF235, 0, 0, 0, 0, 0);
    do_cycle(0, 0, 0, 0, 16'h0000, 16'h0001, 0, 0, 0, 0, 0);
    do_cycle(1, 0, 1, 1, 16'hABCD, 16'hABCE, 16'hF0F3, 8'h00, 8'h77, 8'h3C, 1);
    do_cycle(1, 1, 0, 1, 16'hABCE, 16'hABCF, 16'h0042, 8'h99, 8'hE5, 8'h00, 1);
    do_cycle(1, 1, 1, 0, 16'h0000, 16'h0000, 16'hFFFF, 8'h5A, 8'h11, 8'h00, 0);
    do_cycle(0, 0, 0, 1, 16'hFFFF, 16'hC00F, 0, 0, 0, 0, 1);
    for (int i = 0; i < 80; i++) begin
      bit d, w, wide, fe, prot;
      logic [15:0] pc1, a;
      d = ($urandom % 3) == 0; w = $urandom; wide = $urandom;
      fe = ($urandom % 4) != 0; prot = ($urandom % 3) == 0;
      pc1 = $urandom; a = $urandom;
      do_cycle(d, w, wide, fe, pc1, pc1 + 16'd1 + 16'($urandom % 200), a,
               8'($urandom), 8'($urandom), 8'($urandom), prot);
    end
    do_cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule